// File: doc/BRIEF.md
# Dual-Width Timer/Counter with Compare Match

This block is a timer/counter driven by a prescaled tick enable. One control bit picks its width: either only the low byte counts as an 8-bit counter, or the low and high bytes form one 16-bit counter. A second control bit picks the counting mode:

- **Free-running:** the counter wraps at its all-ones value.
- **Clear on match:** the counter returns to zero on the tick where it equals compare A.

Two compare registers each set a sticky match flag. The flags leave the block as interrupt request lines. Software clears a flag by writing a 1 to its bit.

An 8-bit register bus reaches every register. In 16-bit mode a single temporary byte makes every 16-bit access atomic, and that one byte is shared by the counter and the compare pair.

- **Reads:** reading the counter low byte captures the live high byte into the temporary byte.
- **Writes:** writing a high byte only loads the temporary byte. The following low-byte write moves both bytes at once.

Any write of the counter low byte makes the next tick a skip tick. On that tick the counter still increments, but no match is evaluated.

The skip tick is tracked by a two-state guard machine:

| State | Meaning |
|---|---|
| `GUARD_ARMED` | Compare evaluation is enabled. |
| `GUARD_SKIP` | The next tick is not compared. |

| Transition | Condition |
|---|---|
| ARMED → SKIP | Counter-load transition, taken on a counter low-byte write. |
| SKIP → ARMED | Skip-consumed transition, taken on a tick with no load. |
| SKIP → SKIP | Reload transition, taken on another load. |
| Stay in current state | All other cycles. |

Register map (3-bit address):

| Address | Register | Notes |
|---|---|---|
| 0 | Control | Bit 0 selects 16-bit width, bit 1 selects clear-on-match. |
| 1 | Counter low byte | |
| 2 | Counter high byte | |
| 3 | Compare A | Low byte of the 16-bit compare value. |
| 4 | Compare B | High byte of the 16-bit compare value in 16-bit mode. |
| 5 | Flags | Bit 0 is match A, bit 1 is match B. |
| Other | — | Reads return 0. |

Top module: `dwt_top`

## Requirements
- R1: After reset the counter bytes, both compare registers, the control register and the flags all read 0, and both interrupt outputs are low.
- R2: In 8-bit mode the counter low byte advances by one only on a cycle with `tick` high, and wraps from 0xFF to 0x00. The high byte is never changed by counting.
- R3: In 16-bit mode (control bit 0 set) the two bytes count as one 16-bit value with carry from low to high, wrapping from 0xFFFF to 0x0000.
- R4: In clear-on-match mode (control bit 1 set), a compared tick on which the counter equals compare A loads 0 instead of incrementing. In 8-bit mode compare A is the low byte alone. In 16-bit mode compare A is {compare B, compare A} against the full counter.
- R5: A compared tick sets flag A (bit 0) when the match-A condition of R4 holds. It sets flag B (bit 1) when compare B equals the counter low byte (8-bit mode) or the counter high byte (16-bit mode). Flags stay set until cleared.
- R6: Writing the flag register clears each flag whose bit is written 1 and leaves flags written 0 untouched. A flag set on the same cycle wins over its clear.
- R7: A write to the counter low byte loads it. In 16-bit mode it also loads the high byte from the temporary byte in the same cycle. The write overrides a tick in that cycle.
- R8: The first tick after a counter low-byte write sets no flag and performs no clear-on-match; the counter increments instead. Later ticks compare normally.
- R9: In 16-bit mode, reading the counter low byte copies the live high byte into the temporary byte. Reading the counter high byte returns the temporary byte, not the live high byte.
- R10: In 16-bit mode a write to the counter high byte or to compare B changes only the temporary byte; the visible counter and compare B keep their values.
- R11: In 16-bit mode a write to compare A loads compare A from the bus and compare B from the temporary byte in one cycle, whichever register last filled the temporary byte.
- R12: In 8-bit mode writes to the counter high byte and to compare B update them directly, and the counter high byte reads its live value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled timer-clock enable |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives temporary-byte capture) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| irq_a | output | 1 | Match A flag |
| irq_b | output | 1 | Match B flag |

## Verification
A guard machine stuck in the wrong state shows up at the ports within one tick. It appears either as a flag rising on the tick right after a counter write, or as a missed flag or clear on a tick after that.

A corrupted temporary byte is invisible until the next high-byte read or low-byte write. At that point it appears as a wrong counter high byte or a wrong compare B value, so the bench reads both back after every staged access.

Counter or compare errors surface one tick later as a wrong low byte or a flag pattern that differs from the hand-computed sequence.

// File: rtl/dwt_pkg.sv
package dwt_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP_A  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMP_B  = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd5;

    typedef enum logic {
        GUARD_ARMED = 1'b0,
        GUARD_SKIP  = 1'b1
    } guard_e;
endpackage

// File: rtl/dwt_core.sv
module dwt_core
    import dwt_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            wide,
    input  logic            ctc,
    input  logic [W-1:0]    cmp_a,
    input  logic [W-1:0]    cmp_b,
    input  logic            ld_lo,
    input  logic            ld_hi_en,
    input  logic [2*W-1:0]  ld_val,
    input  logic            hi_wr,
    input  logic [W-1:0]    hi_val,
    input  logic [1:0]      flag_clr,
    output logic [2*W-1:0]  cnt,
    output logic [1:0]      flags
);
    localparam int CW = 2 * W;
    localparam logic [CW-1:0] ONE_C = CW'(1);
    localparam logic [W-1:0]  ONE_B = W'(1);

    guard_e         guard_q, guard_d;
    logic [CW-1:0]  cnt_d;
    logic [1:0]     flags_d;
    logic           match_a, match_b, eval, clear_now;

    // guard state register
    always_ff @(posedge clk) begin
        if (!rst_n) guard_q <= GUARD_ARMED;
        else        guard_q <= guard_d;
    end

    // guard next state
    always_comb begin
        guard_d = guard_q;
        unique case (guard_q)
            GUARD_ARMED: if (ld_lo) guard_d = GUARD_SKIP;
            GUARD_SKIP: begin
                if (ld_lo)     guard_d = GUARD_SKIP;
                else if (tick) guard_d = GUARD_ARMED;
            end
        endcase
    end

    // compare and counter outputs
    always_comb begin
        match_a   = wide ? (cnt == {cmp_b, cmp_a}) : (cnt[W-1:0] == cmp_a);
        match_b   = wide ? (cnt[CW-1:W] == cmp_b) : (cnt[W-1:0] == cmp_b);
        eval      = tick && !ld_lo && (guard_q == GUARD_ARMED);
        clear_now = eval && ctc && match_a;

        cnt_d = cnt;
        if (ld_lo) begin
            if (ld_hi_en) cnt_d = ld_val;
            else          cnt_d[W-1:0] = ld_val[W-1:0];
        end else begin
            if (hi_wr) cnt_d[CW-1:W] = hi_val;
            if (tick) begin
                if (clear_now) begin
                    cnt_d[W-1:0] = '0;
                    if (wide) cnt_d[CW-1:W] = '0;
                end else if (wide) begin
                    cnt_d = cnt + ONE_C;
                end else begin
                    cnt_d[W-1:0] = cnt[W-1:0] + ONE_B;
                end
            end
        end

        flags_d = (flags & ~flag_clr) | {eval && match_b, eval && match_a};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            flags <= '0;
        end else begin
            cnt   <= cnt_d;
            flags <= flags_d;
        end
    end

    AST_SKIP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_q == GUARD_SKIP && tick && !ld_lo) |=> (!$rose(flags[0]) && !$rose(flags[1]))); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_lo && !hi_wr) |=> $stable(cnt)); // R2
    AST_CTC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_lo && guard_q == GUARD_ARMED && ctc && match_a) |=> (cnt[W-1:0] == '0)); // R4
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lo |=> (cnt[W-1:0] == $past(ld_val[W-1:0]))); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr == 2'b00) |=> ((flags & $past(flags)) == $past(flags))); // R5
endmodule

// File: rtl/dwt_bus.sv
module dwt_bus
    import dwt_pkg::*;
#(
    parameter int W = BYTE_W,
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic            wr,
    input  logic            rd,
    input  logic [W-1:0]    wdata,
    input  logic [2*W-1:0]  cnt,
    input  logic [1:0]      flags,
    output logic [W-1:0]    rdata,
    output logic            wide,
    output logic            ctc,
    output logic [W-1:0]    cmp_a,
    output logic [W-1:0]    cmp_b,
    output logic            ld_lo,
    output logic            ld_hi_en,
    output logic [2*W-1:0]  ld_val,
    output logic            hi_wr,
    output logic [W-1:0]    hi_val,
    output logic [1:0]      flag_clr
);
    localparam int CW = 2 * W;

    logic [1:0]   ctrl_q;
    logic [W-1:0] temp_q;

    assign wide = ctrl_q[0];
    assign ctc  = ctrl_q[1];

    always_comb begin
        ld_lo    = wr && (addr == A_CNT_LO);
        ld_hi_en = wide;
        ld_val   = {temp_q, wdata};
        hi_wr    = wr && (addr == A_CNT_HI) && !wide;
        hi_val   = wdata;
        flag_clr = (wr && addr == A_FLAGS) ? wdata[1:0] : 2'b00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmp_a  <= '0;
            cmp_b  <= '0;
            temp_q <= '0;
        end else if (wr) begin
            case (addr)
                A_CTRL:   ctrl_q <= wdata[1:0];
                A_CNT_HI: if (wide) temp_q <= wdata;
                A_CMP_A: begin
                    cmp_a <= wdata;
                    if (wide) cmp_b <= temp_q;
                end
                A_CMP_B: begin
                    if (wide) temp_q <= wdata;
                    else      cmp_b  <= wdata;
                end
                default: ;
            endcase
        end else if (rd && wide && addr == A_CNT_LO) begin
            temp_q <= cnt[CW-1:W];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata = W'(ctrl_q);
            A_CNT_LO: rdata = cnt[W-1:0];
            A_CNT_HI: rdata = wide ? temp_q : cnt[CW-1:W];
            A_CMP_A:  rdata = cmp_a;
            A_CMP_B:  rdata = cmp_b;
            A_FLAGS:  rdata = W'(flags);
            default:  rdata = '0;
        endcase
    end

    AST_CMPB_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_CMP_B && wide) |=> $stable(cmp_b)); // R10
    AST_CMP_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_CMP_A && wide) |=> (cmp_b == $past(temp_q))); // R11
    AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && wide && addr == A_CNT_LO) |=> (temp_q == $past(cnt[CW-1:W]))); // R9
endmodule

// File: rtl/dwt_top.sv
module dwt_top
    import dwt_pkg::*;
#(
    parameter int W  = BYTE_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    output logic          irq_a,
    output logic          irq_b
);
    logic [2*W-1:0] cnt, ld_val;
    logic [1:0]     flags, flag_clr;
    logic           wide, ctc, ld_lo, ld_hi_en, hi_wr;
    logic [W-1:0]   cmp_a, cmp_b, hi_val;

    dwt_bus #(.W(W), .AW(AW)) u_bus (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .cnt(cnt), .flags(flags), .rdata(bus_rdata),
        .wide(wide), .ctc(ctc), .cmp_a(cmp_a), .cmp_b(cmp_b), .ld_lo(ld_lo),
        .ld_hi_en(ld_hi_en), .ld_val(ld_val), .hi_wr(hi_wr), .hi_val(hi_val),
        .flag_clr(flag_clr)
    );

    dwt_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wide(wide), .ctc(ctc),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .ld_lo(ld_lo), .ld_hi_en(ld_hi_en),
        .ld_val(ld_val), .hi_wr(hi_wr), .hi_val(hi_val), .flag_clr(flag_clr),
        .cnt(cnt), .flags(flags)
    );

    assign irq_a = flags[0];
    assign irq_b = flags[1];

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq_a && !irq_b)); // R1
endmodule

// File: tb/dwt_top_tb.sv
module dwt_top_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_a, irq_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dwt_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_a(irq_a), .irq_b(irq_b)
    );

    // {ctrl, cmpA, cmpB, start, ticks, expected count, expected flags}
    localparam logic [55:0] VEC [0:5] = '{
        {8'h00, 8'h10, 8'h20, 8'h0E, 8'd4, 8'h12, 8'h01},  // R5 flag A, normal
        {8'h00, 8'h05, 8'hFE, 8'hFC, 8'd5, 8'h01, 8'h02},  // R2 wrap, R5 flag B
        {8'h02, 8'h03, 8'h01, 8'h00, 8'd6, 8'h02, 8'h03},  // R4 clear on match
        {8'h02, 8'h07, 8'h50, 8'h07, 8'd2, 8'h09, 8'h00},  // R8 skip tick
        {8'h02, 8'h07, 8'h50, 8'h06, 8'd3, 8'h01, 8'h01},  // R8 then R4
        {8'h00, 8'h00, 8'h00, 8'hFF, 8'd1, 8'h00, 8'h00}   // R8 no flag at 0
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic rchk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 6; a++) rchk("R1", 3'(a), 8'h00);
        chk("R1 irq", {6'b0, irq_b, irq_a}, 8'h00);

        // R2 counting gated by tick, R12 direct high byte
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h05);
        repeat (5) @(negedge clk);
        rchk("R2 no tick", 3'd1, 8'h05);
        wr(3'd2, 8'hAB);
        rchk("R12 direct hi", 3'd2, 8'hAB);
        ticks(3);
        rchk("R2 count", 3'd1, 8'h08);
        rchk("R2 hi untouched", 3'd2, 8'hAB);

        // table of 8-bit vectors
        for (int i = 0; i < 6; i++) begin
            wr(3'd0, VEC[i][55:48]);
            wr(3'd3, VEC[i][47:40]);
            wr(3'd4, VEC[i][39:32]);   // R12 direct compare B
            wr(3'd5, 8'h03);
            wr(3'd1, VEC[i][31:24]);
            ticks(int'(VEC[i][23:16]));
            rchk("R2/R4/R8 vector count", 3'd1, VEC[i][15:8]);
            rchk("R5/R8 vector flags", 3'd5, VEC[i][7:0]);
        end

        // R3, R7, R9 16-bit counting
        wr(3'd0, 8'h01);
        wr(3'd2, 8'h12);
        wr(3'd1, 8'hFE);
        rchk("R7 lo", 3'd1, 8'hFE);
        rchk("R7 hi via temp", 3'd2, 8'h12);
        ticks(3);
        rchk("R3 carry lo", 3'd1, 8'h01);
        rchk("R3 carry hi", 3'd2, 8'h13);
        // R10 staged high write leaves counter
        wr(3'd2, 8'h77);
        rchk("R10 lo", 3'd1, 8'h01);
        rchk("R10 hi unchanged", 3'd2, 8'h13);
        // R3 16-bit wrap
        wr(3'd2, 8'hFF);
        wr(3'd1, 8'hFF);
        ticks(2);
        rchk("R3 wrap lo", 3'd1, 8'h01);
        rchk("R3 wrap hi", 3'd2, 8'h00);
        // R9 stale temporary byte
        wr(3'd2, 8'h00);
        wr(3'd1, 8'hFF);
        rchk("R9 lo", 3'd1, 8'hFF);
        ticks(2);
        rchk("R9 hi from temp", 3'd2, 8'h00);
        rchk("R9 lo live", 3'd1, 8'h01);
        rchk("R9 hi refreshed", 3'd2, 8'h01);

        // R10, R11 compare pair through the shared byte
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h01);
        wr(3'd4, 8'h02);
        rchk("R10 cmpB staged", 3'd4, 8'h00);
        wr(3'd3, 8'h05);
        rchk("R11 cmpB atomic", 3'd4, 8'h02);
        rchk("R11 cmpA", 3'd3, 8'h05);
        wr(3'd2, 8'h03);
        wr(3'd3, 8'h09);
        rchk("R11 shared temp", 3'd4, 8'h03);

        // R4, R5 16-bit clear on match
        wr(3'd0, 8'h03);
        wr(3'd2, 8'h03);
        wr(3'd1, 8'h07);
        wr(3'd5, 8'h03);
        ticks(3);
        rchk("R4 16 clear lo", 3'd1, 8'h00);
        rchk("R4 16 clear hi", 3'd2, 8'h00);
        rchk("R5 16 flags", 3'd5, 8'h03);
        chk("R5 irq ports", {6'b0, irq_b, irq_a}, 8'h03);

        // R6 write-one-to-clear
        wr(3'd5, 8'h01);
        rchk("R6 clear A", 3'd5, 8'h02);
        wr(3'd5, 8'h00);
        rchk("R6 zero keeps", 3'd5, 8'h02);
        wr(3'd5, 8'h02);
        rchk("R6 clear B", 3'd5, 8'h00);

        // R7 load beats simultaneous tick
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h41);
        @(negedge clk);
        tick = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h40; bus_wr = 1'b1;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
        rchk("R7 load wins", 3'd1, 8'h40);
        ticks(1);
        rchk("R8 skip tick counts", 3'd1, 8'h41);
        rchk("R8 skip no flag", 3'd5, 8'h00);
        // R6 set wins over clear
        @(negedge clk);
        tick = 1'b1; bus_addr = 3'd5; bus_wdata = 8'h01; bus_wr = 1'b1;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
        rchk("R6 set wins", 3'd5, 8'h01);
        rchk("R2 after match", 3'd1, 8'h42);

        done = 1;
        finish_run();
    end
endmodule